// File: doc/BRIEF.md
# Extended Data Read Timeout Counter

This block holds the two watchdog timers that a card host controller runs while it waits for the card. The response timer measures the gap between the end of a command and the start bit of the card's reply. The data timer measures the gap before read data arrives. Either timer raises its own sticky flag when the gap runs past its limit. Both timers count card-clock ticks. A tick comes once every divide ratio of system clocks, and that ratio is taken from the clock divider setting.

A single 32-bit configuration word sets both limits. The low byte is the response limit in card clocks. The upper 24 bits hold the data limit in an extended form. A 3-bit multiplier of 0xFFFFFF is added to a coarse count in units of eight, so the data limit can go beyond a plain 24-bit count, up to 0x6FFFFF2 clocks. The block also returns the decoded data limit in clocks, so that software can read the effective value back.

Top module: `rd_timeout_unit`

## Requirements
- R1: After reset both timeout flags are 0, and neither timer runs until it gets a start event.
- R2: The data limit readback `dat_limit_clks_o` equals (M − 1) × 16777215 + C × 8. Here M is `tmo_cfg[10:8]`, and a value of 0 is taken as 1. C is `tmo_cfg[31:11]`.
- R3: A data field `tmo_cfg[31:8]` of all ones decodes to 0x6FFFFF2, the largest limit. No field value decodes to more than that.
- R4: One card-clock tick lasts R system clocks. R is twice `clk_div`, or 1 when `clk_div` is 0. A timer that starts at a clock edge expires exactly L × R edges later, where L is its limit in ticks and a limit of 0 counts as 1.
- R5: A pulse on `cmd_end_i` starts the response timer with limit L = `tmo_cfg[7:0]`. When the limit is reached, `rsp_tmo_o` rises.
- R6: A pulse on `rsp_start_i` stops the response timer, and `rsp_tmo_o` stays 0.
- R7: A pulse on `rd_cmd_end_i` starts the data timer with the decoded data limit. When the limit is reached, `dat_tmo_o` rises.
- R8: A pulse on `blk_start_i` restarts the data timer from zero. The expiry then falls a full limit after the restart.
- R9: A pulse on `blk_done_i` or on `xfer_done_i` stops the data timer, and `dat_tmo_o` stays 0.
- R10: Each flag stays set until its clear input is pulsed. A clear pulse drops the flag one cycle later. An expiry in the same cycle as a clear wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_cfg | input | 32 | Timeout word: [7:0] response limit, [31:8] extended data limit |
| clk_div | input | 8 | Card clock divider setting |
| cmd_end_i | input | 1 | Command transmission finished |
| rsp_start_i | input | 1 | Response start bit seen |
| rd_cmd_end_i | input | 1 | Read command finished |
| blk_start_i | input | 1 | A received data block begins |
| blk_done_i | input | 1 | A received data block completed |
| xfer_done_i | input | 1 | Whole transfer completed |
| rsp_tmo_clr_i | input | 1 | Write-one-to-clear for the response flag |
| dat_tmo_clr_i | input | 1 | Write-one-to-clear for the data flag |
| rsp_tmo_o | output | 1 | Sticky response timeout flag |
| dat_tmo_o | output | 1 | Sticky data read timeout flag |
| dat_limit_clks_o | output | 32 | Decoded data limit in card clocks |

## Verification
The bench sweeps every multiplier value, including 0, across coarse counts that run from zero to all ones. A decoder that let a multiplier of 0 wrap would give a readback near 2^32. One that dropped the scale of eight would come out short. It runs both timers under several divider settings, with limits of 0 and 1 among them. The check samples the cycle before the expected expiry and the cycle of it, so an off-by-one prescaler or an odd divide ratio is caught. A separate set of tests covers events that arrive mid-count: a restart, each of the three stop inputs, and a clear in the same cycle as an expiry. A design that kept its old count, ignored a stop, or let the clear win would fire early, fire at all, or lose the flag.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  localparam int CFG_W     = 32;
  localparam int RSP_W     = 8;
  localparam int FIELD_W   = CFG_W - RSP_W;
  localparam int MULT_W    = 3;
  localparam int COARSE_W  = FIELD_W - MULT_W;
  localparam int LIMIT_W   = 27;
  localparam logic [31:0] SPAN      = 32'h00FF_FFFF;
  localparam logic [31:0] LIMIT_MAX = 32'h06FF_FFF2;

  // Extended data limit: (mult-1)*0xFFFFFF + coarse*8, with mult 0 read as 1
  function automatic logic [31:0] decode_limit(input logic [FIELD_W-1:0] f);
    logic [31:0] m;
    m = (f[MULT_W-1:0] == '0) ? 32'd1 : {29'd0, f[MULT_W-1:0]};
    return (m - 32'd1) * SPAN + {8'd0, f[FIELD_W-1:MULT_W], 3'b000};
  endfunction

  // Card clock ratio: twice the divider, divider 0 meaning 1
  function automatic logic [8:0] card_ratio(input logic [7:0] d);
    return (d == 8'd0) ? 9'd1 : {d, 1'b0};
  endfunction
endpackage

// File: rtl/tmo_decode.sv
module tmo_decode
  import rdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic [7:0]          div_i,
  output logic [LIMIT_W-1:0]  rsp_limit_o,
  output logic [LIMIT_W-1:0]  dat_limit_o,
  output logic [8:0]          ratio_o,
  output logic [31:0]         readback_o
);
  logic [31:0] dec_w;

  always_comb begin
    dec_w       = decode_limit(cfg_i[CFG_W-1:RSP_W]);
    readback_o  = dec_w;
    dat_limit_o = dec_w[LIMIT_W-1:0];
    rsp_limit_o = {{(LIMIT_W-RSP_W){1'b0}}, cfg_i[RSP_W-1:0]};
    ratio_o     = card_ratio(div_i);
  end

  // R3: the decoded limit never passes the ceiling
  a_r3_limit_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    readback_o <= LIMIT_MAX);
  // R4: a tick period is never zero
  a_r4_ratio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_o != 9'd0);
endmodule

// File: rtl/tmo_timer.sv
module tmo_timer #(
  parameter int CNT_W = 27,
  parameter int RAT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [RAT_W-1:0] ratio_i,
  output logic             expire_o,
  output logic             running_o
);
  logic [RAT_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick_w;
  logic             hit_w;
  logic [CNT_W:0]   cnt_inc_w;

  always_comb begin
    tick_w    = running_o && (pre_q == ratio_i - 1'b1);
    cnt_inc_w = {1'b0, cnt_q} + 1'b1;
    hit_w     = tick_w && (cnt_inc_w >= {1'b0, limit_i});
    expire_o  = hit_w && !stop_i && !start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_o <= 1'b0;
      pre_q     <= '0;
      cnt_q     <= '0;
    end else if (start_i) begin
      running_o <= 1'b1;
      pre_q     <= '0;
      cnt_q     <= '0;
    end else if (stop_i || hit_w) begin
      running_o <= 1'b0;
    end else if (running_o) begin
      if (tick_w) begin
        pre_q <= '0;
        cnt_q <= cnt_inc_w[CNT_W-1:0];
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R9 / R6: a stop without a start halts the timer
  a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !running_o);
  // R4: the prescaler stays inside one tick period
  a_r4_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> (pre_q < ratio_i));
  // R5: expiry only from a running timer, which then stops
  a_r5_expire_running: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> running_o);
  a_r5_expire_stops: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !running_o);
  // R8: a start always leaves the timer running
  a_r8_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> running_o);
endmodule

// File: rtl/tmo_flag.sv
module tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R10: sticky without a clear, set beats clear
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/rd_timeout_unit.sv
module rd_timeout_unit
  import rdt_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tmo_cfg,
  input  logic [7:0]  clk_div,
  input  logic        cmd_end_i,
  input  logic        rsp_start_i,
  input  logic        rd_cmd_end_i,
  input  logic        blk_start_i,
  input  logic        blk_done_i,
  input  logic        xfer_done_i,
  input  logic        rsp_tmo_clr_i,
  input  logic        dat_tmo_clr_i,
  output logic        rsp_tmo_o,
  output logic        dat_tmo_o,
  output logic [31:0] dat_limit_clks_o
);
  localparam int CH_RSP = 0;
  localparam int CH_DAT = 1;

  logic [LIMIT_W-1:0] rsp_limit_w, dat_limit_w;
  logic [8:0]         ratio_w;
  logic [LIMIT_W-1:0] limit_w  [NUM_CH];
  logic [NUM_CH-1:0]  start_w, stop_w, clr_w, expire_w, running_w, flag_w;

  tmo_decode u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_i       (tmo_cfg),
    .div_i       (clk_div),
    .rsp_limit_o (rsp_limit_w),
    .dat_limit_o (dat_limit_w),
    .ratio_o     (ratio_w),
    .readback_o  (dat_limit_clks_o)
  );

  always_comb begin
    start_w[CH_RSP] = cmd_end_i;
    stop_w[CH_RSP]  = rsp_start_i;
    clr_w[CH_RSP]   = rsp_tmo_clr_i;
    limit_w[CH_RSP] = rsp_limit_w;
    start_w[CH_DAT] = rd_cmd_end_i | blk_start_i;
    stop_w[CH_DAT]  = blk_done_i | xfer_done_i;
    clr_w[CH_DAT]   = dat_tmo_clr_i;
    limit_w[CH_DAT] = dat_limit_w;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmo_timer #(.CNT_W(LIMIT_W), .RAT_W(9)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_w[c]),
      .stop_i    (stop_w[c]),
      .limit_i   (limit_w[c]),
      .ratio_i   (ratio_w),
      .expire_o  (expire_w[c]),
      .running_o (running_w[c])
    );
    tmo_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (expire_w[c]),
      .clr_i  (clr_w[c]),
      .flag_o (flag_w[c])
    );
  end

  assign rsp_tmo_o = flag_w[CH_RSP];
  assign dat_tmo_o = flag_w[CH_DAT];

  // R6: the response start bit leaves no response flag behind
  a_r6_rsp_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_start_i && !cmd_end_i && !rsp_tmo_o && !rsp_tmo_clr_i) |=> !rsp_tmo_o);
  // R9: block or transfer completion leaves no data flag behind
  a_r9_dat_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((blk_done_i || xfer_done_i) && !rd_cmd_end_i && !blk_start_i && !dat_tmo_o)
      |=> !dat_tmo_o);
endmodule

// File: tb/rd_timeout_unit_tb.sv
module rd_timeout_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tmo_cfg = '0;
  logic [7:0]  clk_div = '0;
  logic cmd_end_i = 0, rsp_start_i = 0, rd_cmd_end_i = 0, blk_start_i = 0;
  logic blk_done_i = 0, xfer_done_i = 0, rsp_tmo_clr_i = 0, dat_tmo_clr_i = 0;
  logic        rsp_tmo_o, dat_tmo_o;
  logic [31:0] dat_limit_clks_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rd_timeout_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tmo_cfg(tmo_cfg), .clk_div(clk_div),
    .cmd_end_i(cmd_end_i), .rsp_start_i(rsp_start_i), .rd_cmd_end_i(rd_cmd_end_i),
    .blk_start_i(blk_start_i), .blk_done_i(blk_done_i), .xfer_done_i(xfer_done_i),
    .rsp_tmo_clr_i(rsp_tmo_clr_i), .dat_tmo_clr_i(dat_tmo_clr_i),
    .rsp_tmo_o(rsp_tmo_o), .dat_tmo_o(dat_tmo_o), .dat_limit_clks_o(dat_limit_clks_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic longint exp_limit(input longint field);
    longint m;
    m = field % 8;
    if (m == 0) m = 1;
    return m * 16777215 - 16777215 + (field / 8) * 8;
  endfunction

  function automatic int ratio_of(input int d);
    return (d == 0) ? 1 : d + d;
  endfunction

  task automatic pulse_start(input int ch);
    @(negedge clk);
    if (ch == 0) cmd_end_i = 1; else rd_cmd_end_i = 1;
    @(negedge clk);
    cmd_end_i = 0; rd_cmd_end_i = 0;
  endtask

  task automatic clear_flag(input int ch, input string req);
    if (ch == 0) rsp_tmo_clr_i = 1; else dat_tmo_clr_i = 1;
    @(negedge clk);
    rsp_tmo_clr_i = 0; dat_tmo_clr_i = 0;
    check(req, {31'd0, (ch == 0) ? rsp_tmo_o : dat_tmo_o}, 32'd0);
  endtask

  // Start a timer and verify the exact expiry edge (R4 plus R5 or R7)
  task automatic expire_test(input int ch, input int cycles, input string req);
    pulse_start(ch);
    repeat (cycles - 1) @(negedge clk);
    check(req, {31'd0, (ch == 0) ? rsp_tmo_o : dat_tmo_o}, 32'd0);
    @(negedge clk);
    check(req, {31'd0, (ch == 0) ? rsp_tmo_o : dat_tmo_o}, 32'd1);
    clear_flag(ch, "R10 clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, idle timers raise nothing
    check("R1 rsp flag", {31'd0, rsp_tmo_o}, 32'd0);
    check("R1 dat flag", {31'd0, dat_tmo_o}, 32'd0);
    repeat (10) @(negedge clk);
    check("R1 idle", {30'd0, rsp_tmo_o, dat_tmo_o}, 32'd0);

    // R2: readback sweep over every multiplier and assorted coarse counts
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 6; k++) begin
        int coarse;
        longint f;
        case (k)
          0: coarse = 0;
          1: coarse = 1;
          2: coarse = 5;
          3: coarse = 21'h0AAAAA;
          4: coarse = 21'h155555;
          default: coarse = 21'h1FFFFF;
        endcase
        f = longint'(coarse) * 8 + m;
        tmo_cfg = {f[23:0], 8'h5A};
        #1;
        check("R2 decode", dat_limit_clks_o, 32'(exp_limit(f)));
      end
    end
    // R3: all-ones data field gives the ceiling
    tmo_cfg = 32'hFFFF_FF00;
    #1;
    check("R3 max", dat_limit_clks_o, 32'h06FF_FFF2);

    // R5 with R4: response expiry across dividers and limits
    for (int d = 0; d < 4; d++) begin
      for (int j = 0; j < 4; j++) begin
        int lim;
        lim = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 3 : 7;
        clk_div = 8'(d);
        tmo_cfg = {24'd1, 8'(lim)};
        expire_test(0, ((lim == 0) ? 1 : lim) * ratio_of(d), "R5 rsp expiry");
      end
    end

    // R7 with R4: data expiry, multiplier 1, coarse 0..2
    for (int d = 0; d < 3; d++) begin
      for (int c = 0; c < 3; c++) begin
        int lim;
        lim = c * 8;
        clk_div = 8'(d);
        tmo_cfg = {21'(c), 3'd1, 8'd0};
        expire_test(1, ((lim == 0) ? 1 : lim) * ratio_of(d), "R7 dat expiry");
      end
    end
    // R4: a large divider setting
    clk_div = 8'd200;
    tmo_cfg = {24'd1, 8'd2};
    expire_test(0, 2 * 400, "R4 divider 200");

    // R6: response start bit stops the timer
    clk_div = 0;
    tmo_cfg = {21'd1, 3'd1, 8'd6};
    pulse_start(0);
    repeat (2) @(negedge clk);
    rsp_start_i = 1; @(negedge clk); rsp_start_i = 0;
    repeat (20) @(negedge clk);
    check("R6 rsp stopped", {31'd0, rsp_tmo_o}, 32'd0);

    // R8: block start restarts the data count (limit 8 ticks, ratio 1)
    pulse_start(1);
    repeat (4) @(negedge clk);
    blk_start_i = 1; @(negedge clk); blk_start_i = 0;
    repeat (7) @(negedge clk);
    check("R8 no early expiry", {31'd0, dat_tmo_o}, 32'd0);
    @(negedge clk);
    check("R8 expiry after restart", {31'd0, dat_tmo_o}, 32'd1);
    clear_flag(1, "R10 clear");

    // R9: block completion and transfer completion both stop the timer
    pulse_start(1);
    repeat (3) @(negedge clk);
    blk_done_i = 1; @(negedge clk); blk_done_i = 0;
    repeat (20) @(negedge clk);
    check("R9 blk_done stop", {31'd0, dat_tmo_o}, 32'd0);
    pulse_start(1);
    repeat (5) @(negedge clk);
    xfer_done_i = 1; @(negedge clk); xfer_done_i = 0;
    repeat (20) @(negedge clk);
    check("R9 xfer_done stop", {31'd0, dat_tmo_o}, 32'd0);

    // R10: expiry and clear in the same cycle, the flag stays set
    pulse_start(1);
    repeat (7) @(negedge clk);
    dat_tmo_clr_i = 1; @(negedge clk); dat_tmo_clr_i = 0;
    check("R10 set beats clear", {31'd0, dat_tmo_o}, 32'd1);
    repeat (5) @(negedge clk);
    check("R10 sticky", {31'd0, dat_tmo_o}, 32'd1);
    clear_flag(1, "R10 clear after hold");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule